// File: doc/BRIEF.md
# SDIO Card Register Access Filter

This block sits in the command path of an SD-family card, behind the command decoder. For each decoded command index it makes one decision: whether the card answers, with which response type, and whether the request goes on to the memory side. It also selects the I/O operating-condition word as the reply data. Two static straps configure it. The first marks the card as I/O-only or as a combo card (memory plus I/O). The second picks SPI or SD bus mode.

At reset release the block captures the per-function supply-voltage masks. It reduces them to one 24-bit I/O operating-condition word, which is the window that every enabled function supports. On an I/O-only card it blocks reads of the memory-only registers: the card identity, the card-specific data, the configuration register and the extended status. The block also formats the 32-bit card status word that I/O responses carry, and it keeps the single relative card address that the whole card shares.

Top module: `sdio_reg_gate`

## Requirements
- R1: Each cycle with `cmd_valid` high produces exactly one cycle of `dec_valid` on the next clock. `dec_resp` then holds 0 (no response), 1 (normal response) or 2 (illegal-command response). `dec_valid` is low in every other cycle.
- R2: `io_ocr` is the bitwise AND of the 24-bit slices `fn_volt[24*i +: 24]` of every function i whose `fn_enable[i]` bit is set. It is captured while `rst` is high and held after that. If no function is enabled, it is 24'hFFFFFF.
- R3: Plain command 5 gets a normal response with `dec_ocr_sel`=1. Every other decision has `dec_ocr_sel`=0.
- R4: On an I/O-only card (`io_only`=1) in SPI mode (`spi_mode`=1), the gated commands get response 2 and `dec_fwd_mem`=0. The gated commands are plain 9 and 10, and application 13 and 51.
- R5: On an I/O-only card in SD mode (`spi_mode`=0), the gated commands get response 0 and `dec_fwd_mem`=0. SD mode never produces response 2.
- R6: On a combo card (`io_only`=0), the gated commands get response 1 with `dec_fwd_mem`=1, in either bus mode.
- R7: An index is decoded as an application command only when the command accepted just before it had index 55. Without that, 13 and 51 are plain commands and get response 1 with `dec_fwd_mem`=0. Non-gated commands always get response 1 with `dec_fwd_mem`=0.
- R8: With `io_only`=1, one clock after the inputs, `status_word` carries `mem_status` bits 31, 23, 22 and 19 unchanged. Bits 12:9 are 4'hF and all other bits are 0.
- R9: With `io_only`=0, one clock after the inputs, `status_word` equals `mem_status` with bits 12:9 replaced by `mem_state`.
- R10: `rca_q` is the single card address. It loads `rca_din` on the clock after `rca_we` is high and holds its value otherwise.
- R11: In reset, `dec_valid`, `dec_resp`, `dec_fwd_mem`, `dec_ocr_sel`, `status_word` and `rca_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; voltage masks are sampled while high |
| io_only | input | 1 | Static: 1 = I/O-only card, 0 = combo card |
| spi_mode | input | 1 | Static: 1 = SPI bus mode, 0 = SD bus mode |
| fn_enable | input | NFUNC | Static per-function enable |
| fn_volt | input | NFUNC*24 | Static per-function voltage masks, function i at bits 24*i+23:24*i |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_index | input | 6 | Decoded command index |
| mem_status | input | 32 | Status word from the memory side |
| mem_state | input | 4 | Memory controller state code |
| rca_we | input | 1 | Card address write enable |
| rca_din | input | 16 | New card address |
| dec_valid | output | 1 | Decision strobe |
| dec_resp | output | 2 | Response type: 0 none, 1 normal, 2 illegal command |
| dec_fwd_mem | output | 1 | Gated register read passed to the memory side |
| dec_ocr_sel | output | 1 | Reply carries the I/O operating-condition word |
| io_ocr | output | 24 | I/O operating-condition word |
| status_word | output | 32 | Card status word for I/O responses |
| rca_q | output | 16 | Shared relative card address |

## Verification
The hardest case to reach is the application-command window. Whether 13 or 51 is gated depends on the command accepted just before, not on the index alone. The stimulus therefore sends 55 followed directly by the target index. It also sends 55, then an unrelated command, then the target, and the target without any 55 before it. It also sends 55 twice, so that the second 55 is itself decoded while the window is open. Each card-type and bus-mode combination needs its own reset, because the straps and the voltage masks are only meaningful as captured at reset. The bench runs one reset per configuration and checks the captured word each time.

// File: rtl/sdio_gate_pkg.sv
package sdio_gate_pkg;
  localparam int OCR_W  = 24;
  localparam int CMD_W  = 6;
  localparam int STAT_W = 32;
  localparam int RCA_W  = 16;

  typedef enum logic [1:0] {
    RSP_NONE    = 2'd0,
    RSP_NORMAL  = 2'd1,
    RSP_ILLEGAL = 2'd2
  } rsp_e;
endpackage

// File: rtl/sdio_ocr_merge.sv
module sdio_ocr_merge #(
  parameter int NFUNC = 7,
  parameter int W     = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NFUNC-1:0]   fn_enable,
  input  logic [NFUNC*W-1:0] fn_volt,
  output logic [W-1:0]       ocr_q
);
  logic [W-1:0] chain [0:NFUNC];

  assign chain[0] = '1;
  generate
    for (genvar g = 0; g < NFUNC; g++) begin : g_and
      assign chain[g+1] = chain[g] & (fn_enable[g] ? fn_volt[g*W +: W] : {W{1'b1}});
    end
  endgenerate

  // Capture while reset is held; static afterwards.
  always_ff @(posedge clk) begin
    if (rst) ocr_q <= chain[NFUNC];
  end

  AST_OCR_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(ocr_q)) else $error("io_ocr changed outside reset"); // R2
endmodule

// File: rtl/sdio_cmd_classify.sv
module sdio_cmd_classify
  import sdio_gate_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_index,
  input  logic             app_window,
  output logic             is_gated,
  output logic             is_ocr_read,
  output logic             is_app_prefix
);
  always_comb begin
    if (app_window)
      is_gated = (cmd_index == 6'd13) || (cmd_index == 6'd51);
    else
      is_gated = (cmd_index == 6'd9) || (cmd_index == 6'd10);
    is_ocr_read   = !app_window && (cmd_index == 6'd5);
    is_app_prefix = (cmd_index == 6'd55);
  end
endmodule

// File: rtl/sdio_status_fmt.sv
module sdio_status_fmt #(
  parameter int          W         = 32,
  parameter logic [31:0] IO_KEEP   = 32'h80C8_0000,
  parameter int          STATE_LSB = 9,
  parameter int          STATE_W   = 4
) (
  input  logic               io_only,
  input  logic [W-1:0]       mem_status,
  input  logic [STATE_W-1:0] mem_state,
  output logic [W-1:0]       word
);
  always_comb begin
    if (io_only) begin
      word = mem_status & IO_KEEP[W-1:0];
      word[STATE_LSB +: STATE_W] = {STATE_W{1'b1}};
    end else begin
      word = mem_status;
      word[STATE_LSB +: STATE_W] = mem_state;
    end
  end
endmodule

// File: rtl/sdio_reg_gate.sv
module sdio_reg_gate
  import sdio_gate_pkg::*;
#(
  parameter int NFUNC = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   io_only,
  input  logic                   spi_mode,
  input  logic [NFUNC-1:0]       fn_enable,
  input  logic [NFUNC*OCR_W-1:0] fn_volt,
  input  logic                   cmd_valid,
  input  logic [CMD_W-1:0]       cmd_index,
  input  logic [STAT_W-1:0]      mem_status,
  input  logic [3:0]             mem_state,
  input  logic                   rca_we,
  input  logic [RCA_W-1:0]       rca_din,
  output logic                   dec_valid,
  output logic [1:0]             dec_resp,
  output logic                   dec_fwd_mem,
  output logic                   dec_ocr_sel,
  output logic [OCR_W-1:0]       io_ocr,
  output logic [STAT_W-1:0]      status_word,
  output logic [RCA_W-1:0]       rca_q
);
  localparam logic [31:0] IO_KEEP = 32'h80C8_0000;

  logic              app_q;
  logic              gated, ocr_rd, app_pfx;
  logic [STAT_W-1:0] status_d;

  sdio_ocr_merge #(.NFUNC(NFUNC), .W(OCR_W)) ocr_i (
    .clk(clk), .rst(rst), .fn_enable(fn_enable), .fn_volt(fn_volt), .ocr_q(io_ocr)
  );

  sdio_cmd_classify cls_i (
    .cmd_index(cmd_index), .app_window(app_q),
    .is_gated(gated), .is_ocr_read(ocr_rd), .is_app_prefix(app_pfx)
  );

  sdio_status_fmt #(.W(STAT_W), .IO_KEEP(IO_KEEP), .STATE_LSB(9), .STATE_W(4)) st_i (
    .io_only(io_only), .mem_status(mem_status), .mem_state(mem_state), .word(status_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      app_q       <= 1'b0;
      dec_valid   <= 1'b0;
      dec_resp    <= RSP_NONE;
      dec_fwd_mem <= 1'b0;
      dec_ocr_sel <= 1'b0;
    end else begin
      dec_valid   <= cmd_valid;
      dec_resp    <= RSP_NONE;
      dec_fwd_mem <= 1'b0;
      dec_ocr_sel <= 1'b0;
      if (cmd_valid) begin
        app_q       <= app_pfx;
        dec_ocr_sel <= ocr_rd;
        dec_resp    <= RSP_NORMAL;
        if (gated) begin
          if (io_only) dec_resp <= spi_mode ? RSP_ILLEGAL : RSP_NONE;
          else         dec_fwd_mem <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_word <= '0;
      rca_q       <= '0;
    end else begin
      status_word <= status_d;
      if (rca_we) rca_q <= rca_din;
    end
  end

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> dec_valid) else $error("missing decision"); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !dec_valid) else $error("spurious decision"); // R1
  AST_IOONLY_NO_FWD: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && io_only) |-> !dec_fwd_mem) else $error("forward on io-only card"); // R4
  AST_SD_NEVER_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !spi_mode) |-> (dec_resp != RSP_ILLEGAL)) else $error("illegal resp in SD mode"); // R5
  AST_OCR_SEL_NORMAL: assert property (@(posedge clk) disable iff (rst)
    dec_ocr_sel |-> (dec_valid && dec_resp == RSP_NORMAL)) else $error("ocr select without normal resp"); // R3
  AST_IO_STATE_CODE: assert property (@(posedge clk) disable iff (rst)
    io_only |=> (status_word[12:9] == 4'hF)) else $error("state code not F"); // R8
  AST_NA_ZERO: assert property (@(posedge clk) disable iff (rst)
    io_only |=> ((status_word & ~(IO_KEEP | 32'h0000_1E00)) == '0)) else $error("N/A bit set"); // R8
  AST_RCA_LOAD: assert property (@(posedge clk) disable iff (rst)
    rca_we |=> (rca_q == $past(rca_din))) else $error("rca not loaded"); // R10
endmodule

// File: tb/sdio_reg_gate_tb_top.sv
module sdio_reg_gate_tb_top;
  localparam int NF = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          io_only = 1'b1, spi_mode = 1'b1;
  logic [NF-1:0] fn_enable = '0;
  logic [NF*24-1:0] fn_volt = '0;
  logic          cmd_valid = 1'b0;
  logic [5:0]    cmd_index = '0;
  logic [31:0]   mem_status = '0;
  logic [3:0]    mem_state = '0;
  logic          rca_we = 1'b0;
  logic [15:0]   rca_din = '0;
  logic          dec_valid, dec_fwd_mem, dec_ocr_sel;
  logic [1:0]    dec_resp;
  logic [23:0]   io_ocr;
  logic [31:0]   status_word;
  logic [15:0]   rca_q;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  sdio_reg_gate #(.NFUNC(NF)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_ocr(logic [NF-1:0] en, logic [NF*24-1:0] v);
    logic [23:0] r = '1;
    for (int i = 0; i < NF; i++) if (en[i]) r &= v[i*24 +: 24];
    return r;
  endfunction

  task automatic do_reset(bit io, bit spi, logic [NF-1:0] en, logic [NF*24-1:0] v);
    @(negedge clk);
    rst = 1'b1; io_only = io; spi_mode = spi; fn_enable = en; fn_volt = v;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R2 ocr", {8'h0, io_ocr}, {8'h0, ref_ocr(en, v)});
  endtask

  // sends one command; returns at the negedge where the decision is visible
  task automatic send(logic [5:0] idx);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = idx;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_dec(string req, logic [1:0] rsp, bit fwd, bit osel);
    chk({req, " valid"}, {31'h0, dec_valid}, 32'h1);
    chk({req, " resp"}, {30'h0, dec_resp}, {30'h0, rsp});
    chk({req, " fwd"}, {31'h0, dec_fwd_mem}, {31'h0, fwd});
    chk({req, " ocrsel"}, {31'h0, dec_ocr_sel}, {31'h0, osel});
  endtask

  task automatic t_reset_state();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 valid", {31'h0, dec_valid}, 0);
    chk("R11 resp", {30'h0, dec_resp}, 0);
    chk("R11 status", status_word, 0);
    chk("R11 rca", {16'h0, rca_q}, 0);
    chk("R11 fwd", {31'h0, dec_fwd_mem}, 0);
  endtask

  task automatic t_ocr();
    logic [NF*24-1:0] v;
    for (int i = 0; i < NF; i++) v[i*24 +: 24] = 24'hFFFFFF ^ (24'h1 << (i * 3));
    do_reset(1, 1, 7'b0000000, v);
    chk("R2 none enabled", {8'h0, io_ocr}, 32'h00FFFFFF);
    do_reset(1, 1, 7'b0010101, v);
    do_reset(1, 1, 7'b1111111, v);
    send(6'd7);
    chk("R2 held", {8'h0, io_ocr}, {8'h0, ref_ocr(7'b1111111, v)});
  endtask

  task automatic t_io_spi();
    do_reset(1, 1, 7'b1, {NF{24'hFF8000}});
    send(6'd9);  expect_dec("R4 cmd9", 2'd2, 0, 0);
    send(6'd10); expect_dec("R4 cmd10", 2'd2, 0, 0);
    send(6'd55); expect_dec("R7 cmd55", 2'd1, 0, 0);
    send(6'd13); expect_dec("R4 acmd13", 2'd2, 0, 0);
    send(6'd55); send(6'd51); expect_dec("R4 acmd51", 2'd2, 0, 0);
    send(6'd5);  expect_dec("R3 cmd5", 2'd1, 0, 1);
    @(negedge clk);
    chk("R1 single", {31'h0, dec_valid}, 0);
  endtask

  task automatic t_io_sd();
    do_reset(1, 0, 7'b1, {NF{24'hFF8000}});
    send(6'd9);  expect_dec("R5 cmd9", 2'd0, 0, 0);
    send(6'd10); expect_dec("R5 cmd10", 2'd0, 0, 0);
    send(6'd55); send(6'd13); expect_dec("R5 acmd13", 2'd0, 0, 0);
    send(6'd55); send(6'd51); expect_dec("R5 acmd51", 2'd0, 0, 0);
  endtask

  task automatic t_combo();
    for (int m = 0; m < 2; m++) begin
      do_reset(0, m[0], 7'b1, {NF{24'hFF8000}});
      send(6'd9);  expect_dec("R6 cmd9", 2'd1, 1, 0);
      send(6'd10); expect_dec("R6 cmd10", 2'd1, 1, 0);
      send(6'd55); send(6'd13); expect_dec("R6 acmd13", 2'd1, 1, 0);
      send(6'd55); send(6'd51); expect_dec("R6 acmd51", 2'd1, 1, 0);
    end
  endtask

  task automatic t_acmd_window();
    do_reset(1, 1, 7'b1, {NF{24'hFF8000}});
    send(6'd13); expect_dec("R7 plain13", 2'd1, 0, 0);
    send(6'd51); expect_dec("R7 plain51", 2'd1, 0, 0);
    send(6'd55); send(6'd2); send(6'd13); expect_dec("R7 window closed", 2'd1, 0, 0);
    send(6'd55); send(6'd55); send(6'd13); expect_dec("R7 double 55", 2'd2, 0, 0);
    send(6'd55); send(6'd9); expect_dec("R7 app 9 not gated", 2'd1, 0, 0);
    send(6'd55); send(6'd5); expect_dec("R7 app 5 not ocr", 2'd1, 0, 0);
  endtask

  task automatic t_status();
    do_reset(1, 1, 7'b1, {NF{24'hFF8000}});
    @(negedge clk); mem_status = 32'hFFFF_FFFF; mem_state = 4'h4;
    @(negedge clk); chk("R8 all ones", status_word, 32'h80C8_1E00);
    mem_status = 32'h0000_0000;
    @(negedge clk); chk("R8 zeros", status_word, 32'h0000_1E00);
    mem_status = 32'h8040_0000;
    @(negedge clk); chk("R8 some", status_word, 32'h8040_1E00);
    do_reset(0, 1, 7'b1, {NF{24'hFF8000}});
    @(negedge clk); mem_status = 32'hFFFF_FFFF; mem_state = 4'h4;
    @(negedge clk); chk("R9 combo", status_word, 32'hFFFF_E9FF);
    mem_status = 32'h1234_5678; mem_state = 4'hA;
    @(negedge clk); chk("R9 combo2", status_word, 32'h1234_5478);
  endtask

  task automatic t_rca();
    do_reset(1, 1, 7'b1, {NF{24'hFF8000}});
    chk("R10 reset", {16'h0, rca_q}, 0);
    @(negedge clk); rca_we = 1'b1; rca_din = 16'hBEEF;
    @(negedge clk); rca_we = 1'b0; rca_din = 16'h1111;
    chk("R10 load", {16'h0, rca_q}, 32'hBEEF);
    @(negedge clk);
    chk("R10 hold", {16'h0, rca_q}, 32'hBEEF);
  endtask

  initial begin
    t_reset_state();
    t_ocr();
    t_io_spi();
    t_io_sd();
    t_combo();
    t_acmd_window();
    t_status();
    t_rca();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule